// File: doc/BRIEF.md
# Key Matrix Scanner with Interrupt

This block scans a 5 by 5 key matrix. It drives five row lines and reads back five active-low column lines. When no scan is running, all rows are held low. Any closed key then pulls its column low. The block keeps a snapshot of the column levels it last saw while idle. When the synchronized columns differ from that snapshot, a key was pressed or released, and cyclic scanning starts.

During a scan, one row at a time is driven low, from row 0 to row 4, for a fixed number of clock cycles each. At the last cycle of each row period, the column levels are sampled into that row's slice of a 25-bit key-state word. The host reads this word. After the first complete pass over all rows, the interrupt rises. The interrupt stays high and the scan keeps cycling until the host pulses the stop input. The block then drops the interrupt and returns all rows low. It waits for the synchronizer to settle and takes a fresh idle snapshot.

Column inputs go through a two-flop synchronizer. They have no chatter filtering.

Top module: `keymatrix_scanner`

## Requirements
- R1: After reset, and whenever no scan is running, `rowN` is all zeros (every row driven low) and `irq` is 0; `keyState` resets to 0.
- R2: While idle, a key press that pulls a previously high column low starts a scan: rows begin walking within a few cycles.
- R3: While idle, a key release that lets a previously low column return high also starts a scan.
- R4: During a scan exactly one bit of `rowN` is 0. The low bit visits row 0, 1, 2, 3, 4 and then row 0 again, and stays on each row for TICKS_PER_ROW cycles.
- R5: At the end of each row period, `keyState[r*5+c]` is written 1 if column c reads low while row r is driven, and 0 otherwise. Outside these sample points `keyState` holds its value.
- R6: `irq` stays 0 during the first pass. It rises after the row 4 period of that pass completes. It then stays 1 while the scan keeps cycling.
- R7: A one-cycle pulse on `stopScan` during a scan ends it. On the next cycle `irq` is 0 and `rowN` is all zeros. This holds even if the pass had not completed. A pulse on `stopScan` while idle has no effect.
- R8: Keys changed during a running scan appear in `keyState` on later passes without a new start event.
- R9: Idle detection works per column. A change that leaves every idle column level the same, such as closing a second key in an already-low column, starts no scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| colN | input | 5 | Column return lines, low when a key on the driven row is closed |
| stopScan | input | 1 | One-cycle command that ends scanning and clears the interrupt |
| rowN | output | 5 | Row drive lines, 0 = driven low |
| keyState | output | 25 | Stored key map, bit r*5+c set when the key at row r, column c is closed |
| irq | output | 1 | Interrupt, high from the end of the first full pass until stop |

## Verification
A bench model of the matrix computes the column levels from the current row drive and a 25-bit key map. Directed cases separate three situations: a single press, a release of all keys, and a press hidden in an already-low column. Together they show that detection works per column and reacts in both directions. Another case changes keys during a scan, which shows that stored state follows the matrix without a new event. A stop before the first pass completes shows that the interrupt cannot fire late. Sparse random key maps from a fixed seed then mix both outcomes: a scan with a checked key map, or no scan at all. Each outcome is predicted from the idle column view before and after the change.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  localparam int KS_ROWS  = 5;
  localparam int KS_COLS  = 5;
  localparam int KS_ROW_W = $clog2(KS_ROWS);
  localparam int KS_KEYS  = KS_ROWS * KS_COLS;

  // strobes from control to datapath
  typedef struct packed {
    logic                sample;   // capture columns into the current row slice
    logic                snapLoad; // refresh idle column snapshot
    logic [KS_ROW_W-1:0] row;      // row currently driven
  } kscan_strobe_t;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_IDLE   = 2'd1,
    ST_SCAN   = 2'd2
  } kscan_state_e;
endpackage

// File: rtl/kscan_dp.sv
module kscan_dp
  import kscan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [KS_COLS-1:0]  colN,
  input  kscan_strobe_t       strobe,
  output logic                colChange,
  output logic [KS_KEYS-1:0]  keyState
);
  logic [KS_COLS-1:0] syncReg [SYNC_STAGES];
  logic [KS_COLS-1:0] colSync;
  logic [KS_COLS-1:0] idleSnap;

  // column synchronizer chain
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg[s] <= '1;
        else if (s == 0) syncReg[s] <= colN;
        else syncReg[s] <= syncReg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign colSync = syncReg[SYNC_STAGES-1];

  // idle snapshot and change detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idleSnap <= '1;
    else if (strobe.snapLoad) idleSnap <= colSync;
  end
  assign colChange = (colSync != idleSnap);

  // per-row key state slices
  genvar r;
  generate
    for (r = 0; r < KS_ROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) keyState[r*KS_COLS +: KS_COLS] <= '0;
        else if (strobe.sample && strobe.row == KS_ROW_W'(r))
          keyState[r*KS_COLS +: KS_COLS] <= ~colSync;
      end
    end
  endgenerate

  // R5
  key_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sample |=> $stable(keyState));

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.snapLoad |=> $stable(idleSnap));
endmodule

// File: rtl/kscan_ctrl.sv
module kscan_ctrl
  import kscan_pkg::*;
#(
  parameter int TICKS_PER_ROW = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               colChange,
  input  logic               stopScan,
  output kscan_strobe_t      strobe,
  output logic [KS_ROWS-1:0] rowN,
  output logic               irq
);
  localparam int TICK_W     = (TICKS_PER_ROW > 1) ? $clog2(TICKS_PER_ROW) : 1;
  localparam int SETTLE_W   = $clog2(SYNC_STAGES + 1) + 1;
  localparam logic [TICK_W-1:0]   TICK_LAST = TICK_W'(TICKS_PER_ROW - 1);
  localparam logic [KS_ROW_W-1:0] ROW_LAST  = KS_ROW_W'(KS_ROWS - 1);
  localparam logic [SETTLE_W-1:0] SETTLE_LD = SETTLE_W'(SYNC_STAGES);

  initial begin
    if (TICKS_PER_ROW < SYNC_STAGES + 2)
      $error("TICKS_PER_ROW too small for synchronizer depth");
  end

  kscan_state_e         state;
  logic [TICK_W-1:0]    tick;
  logic [KS_ROW_W-1:0]  rowIdx;
  logic [SETTLE_W-1:0]  settleCnt;
  logic                 rowEnd;

  function automatic logic [KS_ROWS-1:0] rowDrive(input logic [KS_ROW_W-1:0] idx);
    return ~(KS_ROWS'(1) << idx);
  endfunction

  function automatic logic [KS_ROWS-1:0] rotl(input logic [KS_ROWS-1:0] v);
    return {v[KS_ROWS-2:0], v[KS_ROWS-1]};
  endfunction

  assign rowEnd = (state == ST_SCAN) && (tick == TICK_LAST);

  always_comb begin
    strobe.sample   = rowEnd && !stopScan;
    strobe.snapLoad = (state == ST_SETTLE);
    strobe.row      = rowIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_SETTLE;
      settleCnt <= SETTLE_LD;
      tick      <= '0;
      rowIdx    <= '0;
      irq       <= 1'b0;
      rowN      <= '0;
    end else begin
      unique case (state)
        ST_SETTLE: begin
          if (settleCnt == '0) state <= ST_IDLE;
          else settleCnt <= settleCnt - 1'b1;
        end
        ST_IDLE: begin
          if (colChange) begin
            state  <= ST_SCAN;
            tick   <= '0;
            rowIdx <= '0;
            rowN   <= rowDrive('0);
          end
        end
        ST_SCAN: begin
          if (stopScan) begin
            state     <= ST_SETTLE;
            settleCnt <= SETTLE_LD;
            irq       <= 1'b0;
            rowN      <= '0;
          end else if (rowEnd) begin
            tick <= '0;
            if (rowIdx == ROW_LAST) begin
              rowIdx <= '0;
              irq    <= 1'b1;
              rowN   <= rowDrive('0);
            end else begin
              rowIdx <= rowIdx + 1'b1;
              rowN   <= rowDrive(rowIdx + 1'b1);
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: state <= ST_SETTLE;
      endcase
    end
  end

  // R1
  idle_rows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_SCAN) |-> (rowN == '0 && !irq));

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && colChange) |=> (state == ST_SCAN && rowN == rowDrive('0)));

  // R4
  row_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && $past(state == ST_SCAN) && rowN != $past(rowN))
      |-> rowN == rotl($past(rowN)));

  // R4
  row_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> ($countones(~rowN) == 1));

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !stopScan) |=> irq);

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(rowN) == rowDrive(ROW_LAST));

  // R7
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && stopScan) |=> (!irq && rowN == '0));
endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner
  import kscan_pkg::*;
#(
  parameter int TICKS_PER_ROW = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [KS_COLS-1:0]  colN,
  input  logic                stopScan,
  output logic [KS_ROWS-1:0]  rowN,
  output logic [KS_KEYS-1:0]  keyState,
  output logic                irq
);
  kscan_strobe_t strobe;
  logic          colChange;

  kscan_ctrl #(
    .TICKS_PER_ROW(TICKS_PER_ROW),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .colChange(colChange),
    .stopScan (stopScan),
    .strobe   (strobe),
    .rowN     (rowN),
    .irq      (irq)
  );

  kscan_dp #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .colN     (colN),
    .strobe   (strobe),
    .colChange(colChange),
    .keyState (keyState)
  );
endmodule

// File: tb/keymatrix_scanner_test.sv
`timescale 1ns/1ps
module keymatrix_scanner_test;
  localparam int ROWS  = 5;
  localparam int COLS  = 5;
  localparam int KEYS  = 25;
  localparam int TICKS = 8;
  localparam int PASS  = ROWS * TICKS;
  localparam int LIMIT = 2 * PASS + 20;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [COLS-1:0] colN;
  logic            stopScan = 1'b0;
  logic [ROWS-1:0] rowN;
  logic [KEYS-1:0] keyState;
  logic            irq;
  logic [KEYS-1:0] keys = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  keymatrix_scanner #(.TICKS_PER_ROW(TICKS), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .colN(colN), .stopScan(stopScan),
    .rowN(rowN), .keyState(keyState), .irq(irq)
  );

  // matrix model: column low if a closed key sits on a driven row
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      colN[c] = 1'b1;
      for (int r = 0; r < ROWS; r++)
        if (keys[r*COLS+c] && !rowN[r]) colN[c] = 1'b0;
    end
  end

  function automatic logic [COLS-1:0] idleView(input logic [KEYS-1:0] k);
    logic [COLS-1:0] v = '1;
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++)
        if (k[r*COLS+c]) v[c] = 1'b0;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitIrq(output bit got);
    got = 1'b0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      if (irq) begin got = 1'b1; break; end
    end
  endtask

  task automatic doStop();
    @(negedge clk) stopScan = 1'b1;
    @(negedge clk) stopScan = 1'b0;
    // R7
    check(irq == 1'b0 && rowN == '0, "R7 stop", {26'd0, irq, rowN}, 32'd0);
    repeat (6) @(negedge clk);
  endtask

  task automatic checkWalk();
    bit walkOk = 1'b1;
    bit irqOk = 1'b1;
    logic [ROWS-1:0] exp;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rowN != '0) break;
    end
    for (int k = 0; k < 2 * PASS; k++) begin
      exp = ~(ROWS'(1) << ((k / TICKS) % ROWS));
      if (rowN != exp && walkOk) begin
        walkOk = 1'b0;
        check(1'b0, "R4 row walk", rowN, exp);
      end
      if (irq != (k >= PASS) && irqOk) begin
        irqOk = 1'b0;
        check(1'b0, "R6 irq timing", irq, (k >= PASS));
      end
      @(negedge clk);
    end
    if (walkOk) check(1'b1, "R4 row walk", 0, 0);
    if (irqOk)  check(1'b1, "R6 irq timing", 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    logic [KEYS-1:0] prev;
    logic [KEYS-1:0] nk;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rowN == '0 && irq == 1'b0, "R1 reset outputs", {26'd0, irq, rowN}, 32'd0);
    check(keyState == '0, "R1 reset keyState", keyState, 32'd0);
    repeat (30) @(negedge clk);
    check(rowN == '0 && irq == 1'b0, "R1 idle quiet", {26'd0, irq, rowN}, 32'd0);

    // R7 stop while idle has no effect
    @(negedge clk) stopScan = 1'b1;
    @(negedge clk) stopScan = 1'b0;
    repeat (5) @(negedge clk);
    check(rowN == '0 && irq == 1'b0, "R7 idle stop", {26'd0, irq, rowN}, 32'd0);

    // R2 single press at row 2 column 3
    keys = '0;
    keys[2*COLS+3] = 1'b1;
    checkWalk();
    waitIrq(got);
    check(got, "R2 press start", got, 1);
    check(keyState == keys, "R5 single key", keyState, keys);

    // R8 change keys during scan
    keys = '0;
    keys[0] = 1'b1;
    keys[4*COLS+4] = 1'b1;
    keys[1*COLS+2] = 1'b1;
    repeat (2 * PASS + 4) @(negedge clk);
    check(keyState == keys, "R8 live update", keyState, keys);
    check(irq == 1'b1, "R6 irq held", irq, 1);
    doStop();

    // R9 extra key in an already-low column
    keys[3*COLS+0] = 1'b1;
    repeat (LIMIT) @(negedge clk);
    check(irq == 1'b0 && rowN == '0, "R9 masked press", {26'd0, irq, rowN}, 32'd0);

    // R3 release of all keys
    keys = '0;
    waitIrq(got);
    check(got, "R3 release start", got, 1);
    check(keyState == '0, "R5 cleared map", keyState, 32'd0);
    doStop();

    // R7 stop before first pass completes
    keys[0*COLS+1] = 1'b1;
    repeat (15) @(negedge clk);
    check(rowN != '0, "R2 scan running", rowN, 0);
    doStop();
    got = 1'b0;
    for (int i = 0; i < 2 * PASS; i++) begin
      @(negedge clk);
      if (irq || rowN != '0) got = 1'b1;
    end
    check(!got, "R7 early stop quiet", got, 0);

    // random sparse key maps
    for (int it = 0; it < 24; it++) begin
      prev = keys;
      nk = KEYS'($urandom & $urandom & $urandom);
      keys = nk;
      if (idleView(nk) != idleView(prev)) begin
        waitIrq(got);
        check(got, "R2 R3 random start", got, 1);
        check(keyState == nk, "R5 random map", keyState, nk);
        doStop();
      end else begin
        repeat (LIMIT) @(negedge clk);
        check(irq == 1'b0 && rowN == '0, "R9 random no event", {26'd0, irq, rowN}, 32'd0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule